// File: doc/BRIEF.md
# Integer ALU with Status Flags

A 32-bit integer execution unit for a simple processor pipeline. On each cycle where `opValid` is high, it takes a destination operand, a source operand and a 4-bit operation code. One clock later it returns a registered result and a write-back strobe. The same edge also updates a 32-bit status-flag register, provided `flagWrEn` is high and the operation affects flags.

The flag word keeps fixed bit positions, so a branch unit can read `flagsReg` directly and test its conditions. All add-type and subtract-type operations run through one shared adder. Subtraction is formed as addition of the inverted source plus one. Compare runs as a subtraction whose result write-back is suppressed. Shift counts use the low five bits of the source operand.

Top module: `intAluFlags`

## Requirements
- R1: After reset `resultData` is 0, `resultWr` is 0 and `flagsReg` is 32'h0000_0002.
- R2: With `opValid` high, opcodes ADD=0, SUB=1, INC=3 and DEC=4 produce dst+src, dst-src, dst+1 and dst-1 (modulo 2^32) on `resultData`, with `resultWr` high, in the cycle after the issuing edge.
- R3: The carry flag takes the carry out of bit 31 on ADD (0) and the borrow on SUB (1) and CMP (2). INC (3) and DEC (4) leave it unchanged.
- R4: The overflow flag is set on signed two's-complement overflow of ADD, SUB, CMP, INC and DEC.
- R5: For every flag-writing operation, the zero flag is set when the 32-bit result is zero, the sign flag equals result bit 31, and the parity flag is set when result bits 7:0 hold an even number of ones.
- R6: The auxiliary flag marks a carry (add, inc) or a borrow (sub, cmp, dec) out of bit 3. Logic and shift operations clear it.
- R7: CMP (opcode 2) sets the flags exactly as SUB would. It drives `resultWr` low and leaves `resultData` unchanged.
- R8: AND=5, OR=6 and XOR=7 return the bitwise function of dst and src. They clear the carry and overflow flags.
- R9: NOT (opcode 8) returns the bitwise inverse of dst and changes no flag.
- R10: SHL (opcode 9) shifts dst left and fills with zeros. SAR (opcode 10) shifts dst right and fills with copies of bit 31. The count is src[4:0]. The carry flag receives the last bit shifted out, and the overflow flag is cleared.
- R11: A shift with src[4:0]==0 returns dst unchanged, with `resultWr` high, and changes no flag.
- R12: Flag positions in `flagsReg` are carry=0, parity=2, auxiliary=4, zero=6, sign=7 and overflow=11. Bit 1 reads 1 and all other bits read 0.
- R13: The flags are unchanged when `opValid` or `flagWrEn` is low. `resultWr` is low and `resultData` holds when `opValid` is low or the opcode is 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation issued this cycle |
| opSel | input | 4 | Operation code |
| dstVal | input | 32 | Destination (first) operand |
| srcVal | input | 32 | Source (second) operand or shift count |
| flagWrEn | input | 1 | Permits the flag register update |
| resultData | output | 32 | Registered result |
| resultWr | output | 1 | Result write-back strobe |
| flagsReg | output | 32 | Status-flag register |

## Verification
The hardest states to reach from the ports involve flags surviving an operation. Examples are INC over 32'hFFFF_FFFF with a carry left by an earlier subtract, and a zero-count shift arriving while flags are non-zero. Both depend on the flag history, not on the current operands. The stimulus therefore sets up known flags with a directed subtract or add, then issues the operation that must keep them. It also uses dedicated operand pairs at 32'h7FFF_FFFF, 32'h8000_0000 and low nibbles of 4'hF and 4'h0. A long random sequence follows, covering every opcode with `opValid` and `flagWrEn` toggled. A behavioural model carries the flags from cycle to cycle and is compared on every clock.

// File: rtl/intAluPkg.sv
package intAluPkg;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_CMP = 4'd2;
  localparam logic [3:0] OP_INC = 4'd3;
  localparam logic [3:0] OP_DEC = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_NOT = 4'd8;
  localparam logic [3:0] OP_SHL = 4'd9;
  localparam logic [3:0] OP_SAR = 4'd10;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  typedef enum logic [1:0] {UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT, UNIT_INV} unitSel_e;
  typedef enum logic [1:0] {FN_AND, FN_OR, FN_XOR, FN_NONE} logicFn_e;

  typedef struct packed {
    logic     wrResult;
    logic     wrFlags;
    logic     wrCarry;
    unitSel_e unitSel;
    logic     subMode;
    logic     oneOperand;
    logicFn_e logicFn;
    logic     shiftRight;
  } aluStrobes_t;
endpackage

// File: rtl/intAluCtrl.sv
module intAluCtrl
  import intAluPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             opValid,
  input  logic [3:0]       opSel,
  input  logic             flagWrEn,
  input  logic [CNT_W-1:0] shiftCount,
  output aluStrobes_t      strobes
);
  logic writesRes, writesFlags, writesCarry;
  logic cntZero;

  assign cntZero = (shiftCount == '0);

  always_comb begin
    strobes     = '0;
    strobes.unitSel = UNIT_ARITH;
    strobes.logicFn = FN_NONE;
    writesRes   = 1'b0;
    writesFlags = 1'b0;
    writesCarry = 1'b0;
    unique case (opSel)
      OP_ADD: begin writesRes = 1'b1; writesFlags = 1'b1; writesCarry = 1'b1; end
      OP_SUB: begin writesRes = 1'b1; writesFlags = 1'b1; writesCarry = 1'b1; strobes.subMode = 1'b1; end
      OP_CMP: begin writesFlags = 1'b1; writesCarry = 1'b1; strobes.subMode = 1'b1; end
      OP_INC: begin writesRes = 1'b1; writesFlags = 1'b1; strobes.oneOperand = 1'b1; end
      OP_DEC: begin
        writesRes = 1'b1; writesFlags = 1'b1;
        strobes.oneOperand = 1'b1; strobes.subMode = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        writesRes = 1'b1; writesFlags = 1'b1; writesCarry = 1'b1;
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicFn = (opSel == OP_AND) ? FN_AND : (opSel == OP_OR) ? FN_OR : FN_XOR;
      end
      OP_NOT: begin writesRes = 1'b1; strobes.unitSel = UNIT_INV; end
      OP_SHL, OP_SAR: begin
        writesRes = 1'b1;
        writesFlags = !cntZero;
        writesCarry = !cntZero;
        strobes.unitSel = UNIT_SHIFT;
        strobes.shiftRight = (opSel == OP_SAR);
      end
      default: ;
    endcase
    strobes.wrResult = opValid && writesRes;
    strobes.wrFlags  = opValid && flagWrEn && writesFlags;
    strobes.wrCarry  = opValid && flagWrEn && writesCarry;
  end
endmodule

// File: rtl/intAluDatapath.sv
module intAluDatapath
  import intAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] dstVal,
  input  logic [WIDTH-1:0] srcVal,
  output logic [WIDTH-1:0] resultData,
  output logic             resultWr,
  output logic [31:0]      flagsReg
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [31:0] FLAGS_RESET = 32'h0000_0002;

  // shared adder
  logic [WIDTH-1:0] addB, addBEff, sumVal;
  logic             carryOut;
  assign addB    = strobes.oneOperand ? WIDTH'(1) : srcVal;
  assign addBEff = strobes.subMode ? ~addB : addB;
  assign {carryOut, sumVal} = {1'b0, dstVal} + {1'b0, addBEff} + {{WIDTH{1'b0}}, strobes.subMode};

  logic arithCf, arithAf, arithOf;
  assign arithCf = carryOut ^ strobes.subMode;
  assign arithAf = dstVal[4] ^ addB[4] ^ sumVal[4];
  assign arithOf = (dstVal[WIDTH-1] == addBEff[WIDTH-1]) && (sumVal[WIDTH-1] != dstVal[WIDTH-1]);

  // logic unit
  logic [WIDTH-1:0] logicVal;
  always_comb begin
    unique case (strobes.logicFn)
      FN_AND:  logicVal = dstVal & srcVal;
      FN_OR:   logicVal = dstVal | srcVal;
      FN_XOR:  logicVal = dstVal ^ srcVal;
      default: logicVal = ~dstVal;
    endcase
  end

  // shifter: one extra bit catches the last bit shifted out
  logic [CNT_W-1:0] shCnt;
  logic [WIDTH:0]   shlWide, sarWide;
  assign shCnt   = srcVal[CNT_W-1:0];
  assign shlWide = {1'b0, dstVal} << shCnt;
  assign sarWide = $signed({dstVal, 1'b0}) >>> shCnt;

  logic [WIDTH-1:0] shiftVal;
  logic             shiftCf;
  assign shiftVal = strobes.shiftRight ? sarWide[WIDTH:1] : shlWide[WIDTH-1:0];
  assign shiftCf  = strobes.shiftRight ? sarWide[0] : shlWide[WIDTH];

  // result select
  logic [WIDTH-1:0] nextRes;
  logic             nextCf, nextAf, nextOf;
  always_comb begin
    nextCf = 1'b0;
    nextAf = 1'b0;
    nextOf = 1'b0;
    unique case (strobes.unitSel)
      UNIT_ARITH: begin nextRes = sumVal; nextCf = arithCf; nextAf = arithAf; nextOf = arithOf; end
      UNIT_LOGIC: nextRes = logicVal;
      UNIT_SHIFT: begin nextRes = shiftVal; nextCf = shiftCf; end
      default:    nextRes = ~dstVal;
    endcase
  end

  logic [31:0] nextFlags;
  always_comb begin
    nextFlags = flagsReg;
    if (strobes.wrFlags) begin
      nextFlags[PF_BIT] = ~^nextRes[7:0];
      nextFlags[AF_BIT] = nextAf;
      nextFlags[ZF_BIT] = (nextRes == '0);
      nextFlags[SF_BIT] = nextRes[WIDTH-1];
      nextFlags[OF_BIT] = nextOf;
    end
    if (strobes.wrCarry) nextFlags[CF_BIT] = nextCf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
      resultWr   <= 1'b0;
      flagsReg   <= FLAGS_RESET;
    end else begin
      resultWr <= strobes.wrResult;
      if (strobes.wrResult) resultData <= nextRes;
      flagsReg <= nextFlags;
    end
  end

  assert_carry_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrFlags && !strobes.wrCarry) |=> flagsReg[CF_BIT] == $past(flagsReg[CF_BIT]));
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrFlags && strobes.wrResult) |=> flagsReg[ZF_BIT] == (resultData == '0));
  assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrFlags && strobes.wrResult) |=> flagsReg[SF_BIT] == resultData[WIDTH-1]);
endmodule

// File: rtl/intAluFlags.sv
module intAluFlags
  import intAluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opSel,
  input  logic [31:0] dstVal,
  input  logic [31:0] srcVal,
  input  logic        flagWrEn,
  output logic [31:0] resultData,
  output logic        resultWr,
  output logic [31:0] flagsReg
);
  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(WIDTH);

  aluStrobes_t strobes;

  intAluCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .opValid(opValid), .opSel(opSel), .flagWrEn(flagWrEn),
    .shiftCount(srcVal[CNT_W-1:0]), .strobes(strobes));

  intAluDatapath #(.WIDTH(WIDTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dstVal(dstVal), .srcVal(srcVal),
    .resultData(resultData), .resultWr(resultWr), .flagsReg(flagsReg));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP) |=> (!resultWr && $stable(resultData)));
  assert_idle_no_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resultWr && $stable(resultData)));
  assert_flags_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && flagWrEn) |=> $stable(flagsReg));
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagWrEn && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR))
      |=> (!flagsReg[CF_BIT] && !flagsReg[OF_BIT] && !flagsReg[AF_BIT]));
  assert_not_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_NOT) |=> $stable(flagsReg));
  assert_fixed_bits_R12: assert property (@(posedge clk) disable iff (!rstN)
    flagsReg[1] && ((flagsReg & ~32'h0000_08D7) == 32'h0));
endmodule

// File: tb/test_intAluFlags.sv
module test_intAluFlags;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic        flagWrEn = 1'b0;
  logic [31:0] resultData;
  logic        resultWr;
  logic [31:0] flagsReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] expRes = '0;
  logic        expWr = 1'b0;
  logic [31:0] expFlags = 32'h2;

  always #10 clk = ~clk;

  intAluFlags i_intAluFlags (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .dstVal(dstVal),
    .srcVal(srcVal), .flagWrEn(flagWrEn), .resultData(resultData),
    .resultWr(resultWr), .flagsReg(flagsReg));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog (R1..) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] packFlags(logic cf, pf, af, zf, sf, ovf);
    logic [31:0] f = 32'h2;
    f[0] = cf; f[2] = pf; f[4] = af; f[6] = zf; f[7] = sf; f[11] = ovf;
    return f;
  endfunction

  function automatic logic signedOvf(longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  task automatic compareAll(string tag);
    checks++;
    if (resultWr !== expWr) begin
      errors++;
      $display("FAIL %s resultWr actual=%0b expected=%0b", tag, resultWr, expWr);
    end
    checks++;
    if (resultData !== expRes) begin
      errors++;
      $display("FAIL %s resultData actual=%h expected=%h", tag, resultData, expRes);
    end
    checks++;
    if (flagsReg !== expFlags) begin
      errors++;
      $display("FAIL %s flags (R12 layout) actual=%h expected=%h", tag, flagsReg, expFlags);
    end
  endtask

  // behavioural reference: one call per issued cycle
  task automatic model(logic [3:0] op, logic [31:0] d, logic [31:0] s, logic v, logic we);
    logic [32:0] w;
    logic [31:0] r = d;
    logic cf = expFlags[0];
    logic af = 1'b0, ovf = 1'b0;
    bit wrR = 0, wrF = 0, keepC = 0;
    longint sd = longint'($signed(d));
    longint ss = longint'($signed(s));
    int c = int'(s[4:0]);
    case (op)
      4'd0: begin w = {1'b0, d} + {1'b0, s}; r = w[31:0]; cf = w[32];
              ovf = signedOvf(sd + ss); af = ((d & 15) + (s & 15)) > 15; wrR = 1; wrF = 1; end
      4'd1, 4'd2: begin w = {1'b0, d} - {1'b0, s}; r = w[31:0]; cf = w[32];
              ovf = signedOvf(sd - ss); af = (d & 15) < (s & 15); wrR = (op == 4'd1); wrF = 1; end
      4'd3: begin r = d + 1; ovf = signedOvf(sd + 1); af = (d & 15) == 15; wrR = 1; wrF = 1; keepC = 1; end
      4'd4: begin r = d - 1; ovf = signedOvf(sd - 1); af = (d & 15) == 0; wrR = 1; wrF = 1; keepC = 1; end
      4'd5: begin r = d & s; cf = 0; wrR = 1; wrF = 1; end
      4'd6: begin r = d | s; cf = 0; wrR = 1; wrF = 1; end
      4'd7: begin r = d ^ s; cf = 0; wrR = 1; wrF = 1; end
      4'd8: begin r = ~d; wrR = 1; end
      4'd9: begin wrR = 1; if (c != 0) begin r = d << c; cf = d[32 - c]; wrF = 1; end end
      4'd10: begin wrR = 1; if (c != 0) begin r = $signed(d) >>> c; cf = d[c - 1]; wrF = 1; end end
      default: ;
    endcase
    expWr = v && wrR;
    if (expWr) expRes = r;
    if (v && we && wrF)
      expFlags = packFlags(keepC ? expFlags[0] : cf, ($countones(r[7:0]) % 2) == 0, af,
                           r == 0, r[31], ovf);
  endtask

  task automatic issue(logic [3:0] op, logic [31:0] d, logic [31:0] s, logic v, logic we, string tag);
    opSel = op; dstVal = d; srcVal = s; opValid = v; flagWrEn = we;
    model(op, d, s, v, we);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after release");

    issue(4'd0, 32'd5, 32'd7, 1, 1, "R2 add");
    issue(4'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, "R3 R5 R6 add carry");
    issue(4'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, "R4 add overflow");
    issue(4'd1, 32'd3, 32'd5, 1, 1, "R3 sub borrow");
    issue(4'd1, 32'h8000_0000, 32'd1, 1, 1, "R4 sub overflow");
    issue(4'd2, 32'd42, 32'd42, 1, 1, "R7 cmp equal");
    issue(4'd2, 32'd1, 32'd2, 1, 1, "R7 cmp borrow");
    issue(4'd3, 32'hFFFF_FFFF, 32'd0, 1, 1, "R3 inc keeps carry");
    issue(4'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, "R3 set carry");
    issue(4'd4, 32'h0, 32'd0, 1, 1, "R3 R6 dec keeps carry");
    issue(4'd4, 32'h8000_0000, 32'd0, 1, 1, "R4 dec overflow");
    issue(4'd5, 32'hF0F0_1234, 32'h0FF0_00FF, 1, 1, "R8 and");
    issue(4'd6, 32'h0, 32'h0, 1, 1, "R8 R5 or zero");
    issue(4'd7, 32'hAAAA_0003, 32'h5555_0000, 1, 1, "R8 xor");
    issue(4'd1, 32'd0, 32'd1, 1, 1, "R3 preset flags");
    issue(4'd8, 32'h1234_5678, 32'd0, 1, 1, "R9 not");
    issue(4'd9, 32'h8000_0001, 32'd1, 1, 1, "R10 shl 1");
    issue(4'd9, 32'h0000_0003, 32'd31, 1, 1, "R10 shl 31");
    issue(4'd10, 32'h8000_0010, 32'd4, 1, 1, "R10 sar");
    issue(4'd10, 32'h4000_0000, 32'd31, 1, 1, "R10 sar 31");
    issue(4'd1, 32'd0, 32'd1, 1, 1, "R3 preset flags");
    issue(4'd9, 32'hDEAD_BEEF, 32'd32, 1, 1, "R11 shl count zero");
    issue(4'd10, 32'h8765_4321, 32'h0000_0100, 1, 1, "R11 sar count zero");
    issue(4'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, "R13 flag write disabled");
    issue(4'd5, 32'h0, 32'h0, 0, 1, "R13 no valid");
    issue(4'd13, 32'h1, 32'h1, 1, 1, "R13 undefined opcode");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [31:0] d = $urandom;
      logic [31:0] s = $urandom;
      if ($urandom_range(0, 3) == 0) d = {28'h7FFF_FFF ^ 28'($urandom_range(0, 1) * 28'hFFF_FFFF), 4'hF};
      if ($urandom_range(0, 7) == 0) s[4:0] = 5'd0;
      issue(op, d, s, $urandom_range(0, 9) != 0, $urandom_range(0, 7) != 0, "R2 R3 R4 R5 R6 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule